// File: doc/BRIEF.md
# Interrupt Presenter with Inter-Processor Request

This block presents interrupts to a single processor. It keeps a current processor priority, a request register that raises an inter-processor interrupt (IPI), and one priority register for each external interrupt line. It picks the most favoured pending request. When that request beats the current priority, it raises one registered interrupt output to the core.

Software uses a 32-bit register port with byte enables. Reading the acknowledge register accepts the presented interrupt. The read returns the old processor priority and the source identifier, and it raises the processor priority to that of the accepted request. Writing the top byte of the same register sets the processor priority. A full-word write of the acknowledged value ends the interrupt. A poll register returns the same word as the acknowledge register without changing any state. External lines are level sensitive, so a line that is still high is presented again once the priority allows it.

Register offsets, byte addressed:

| Offset | Register | Notes |
|--------|----------|-------|
| 0x00 | acknowledge | read accepts the interrupt; any write with byte enable 3 sets the processor priority |
| 0x04 | poll | read only, no side effects |
| 0x0C | IPI request | 8-bit priority in byte lane 0 |
| 0x10 + 4*i | priority of external line i | 8-bit priority in byte lane 0 |

Top module: `irq_presenter`

## Requirements
- R1: After reset the processor priority is 0x00, the IPI request register is 0xff, every line priority register is 0xff, and `irq_out` is low.
- R2: A read at offset 0x00 returns the processor priority as it was before the read in bits 31:24. Bits 23:0 hold the identifier of the presented source: 2 for the IPI, 16+i for external line i, and 0 when nothing is deliverable.
- R3: A read at 0x00 that returns a nonzero identifier sets the processor priority to that request's priority. A read that returns 0 changes nothing.
- R4: A write at 0x00 with byte enable bit 3 set loads wdata[31:24] into the processor priority. The lower bytes have no effect. A value of 0x00 blocks every request and 0xff admits every request whose priority is below 0xff.
- R5: A request is deliverable only when its priority value is strictly lower than the processor priority.
- R6: Writing a value below 0xff to offset 0x0C (byte lane 0) raises an IPI at that priority. Writing 0xff withdraws it. The register reads back in bits 7:0.
- R7: Each line priority register at 0x10+4*i can be written through byte lane 0 and reads back unchanged in bits 7:0. A priority of 0xff masks that line.
- R8: Among pending requests, the lowest priority value wins. On a tie, the IPI beats external lines, and a lower line index beats a higher one.
- R9: A read at offset 0x04 returns the same word that a read at 0x00 would return, and it changes no state.
- R10: External lines are level sensitive. A line still high after its priority is allowed again is presented again.
- R11: `irq_out` is registered. It equals the deliverable condition from the previous clock edge, so it follows any register write or line change within one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| src_lines | input | N_SRC | level interrupt lines, high = requesting |
| bus_sel | input | 1 | register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | byte enables for the write |
| bus_addr | input | AW | byte address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, valid in the cycle of the access |
| irq_out | output | 1 | interrupt request to the core |

## Verification
A wrong processor priority shows up in bits 31:24 of the very next acknowledge or poll read. It also flips `irq_out` one cycle after the state went wrong. A wrong winner in the request selection shows as a wrong identifier on the next read. A poll with hidden side effects shows as a changed priority on the read that follows it.

// File: rtl/irq_presenter.sv
module irq_presenter #(
  parameter int N_SRC    = 4,
  parameter int AW       = 8,
  parameter int EXT_BASE = 16,
  parameter int IPI_ID   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_lines,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [3:0]       bus_be,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq_out
);
  localparam logic [AW-1:0] A_ACK  = AW'(8'h00);
  localparam logic [AW-1:0] A_POLL = AW'(8'h04);
  localparam logic [AW-1:0] A_REQ  = AW'(8'h0C);
  localparam int            SRC_BASE = 16;

  logic [7:0]  cppr, mfrr;
  logic [7:0]  prio [N_SRC];
  logic        best_v, deliv, irq_q;
  logic [7:0]  best_p;
  logic [23:0] best_id, pres_id;

  wire wr     = bus_sel && bus_we;
  wire ack_rd = bus_sel && !bus_we && bus_addr == A_ACK;

  always_comb begin
    best_v  = (mfrr != 8'hff);
    best_p  = mfrr;
    best_id = 24'(IPI_ID);
    for (int i = 0; i < N_SRC; i++) begin
      if (src_lines[i] && prio[i] != 8'hff && (!best_v || prio[i] < best_p)) begin
        best_v  = 1'b1;
        best_p  = prio[i];
        best_id = 24'(EXT_BASE + i);
      end
    end
  end

  assign deliv   = best_v && (best_p < cppr);
  assign pres_id = deliv ? best_id : 24'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr  <= 8'h00;
      mfrr  <= 8'hff;
      irq_q <= 1'b0;
    end else begin
      irq_q <= deliv;
      if (wr && bus_addr == A_ACK && bus_be[3]) cppr <= bus_wdata[31:24];
      else if (ack_rd && deliv)                 cppr <= best_p;
      if (wr && bus_addr == A_REQ && bus_be[0]) mfrr <= bus_wdata[7:0];
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) prio[g] <= 8'hff;
      else if (wr && bus_be[0] && bus_addr == AW'(SRC_BASE + 4*g)) prio[g] <= bus_wdata[7:0];
    end
  end

  always_comb begin
    bus_rdata = 32'd0;
    if (bus_addr == A_ACK || bus_addr == A_POLL) bus_rdata = {cppr, pres_id};
    else if (bus_addr == A_REQ)                  bus_rdata = {24'd0, mfrr};
    for (int i = 0; i < N_SRC; i++)
      if (bus_addr == AW'(SRC_BASE + 4*i)) bus_rdata = {24'd0, prio[i]};
  end

  assign irq_out = irq_q;

  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    deliv |=> irq_out);
  assert_irq_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !deliv |=> !irq_out);
  assert_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cppr == 8'h00) |=> !irq_out);
  assert_ack_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && deliv) |=> (cppr == $past(best_p)));
  assert_poll_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == A_POLL) |=> ($stable(cppr) && $stable(mfrr)));
  assert_strict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && bus_rdata[23:0] != 24'd0) |-> (best_p < cppr));
endmodule

// File: tb/irq_presenter_bench.sv
module irq_presenter_bench;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_lines = '0;
  logic bus_sel = 0, bus_we = 0;
  logic [3:0] bus_be = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq_out;
  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] m_cppr, m_mfrr;
  logic [7:0] m_prio [N];

  irq_presenter #(.N_SRC(N)) u_irq_presenter (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] m_best(output logic [7:0] p);
    logic v = (m_mfrr != 8'hff);
    logic [23:0] id = 24'd2;
    p = m_mfrr;
    for (int i = 0; i < N; i++)
      if (src_lines[i] && m_prio[i] != 8'hff && (!v || m_prio[i] < p)) begin
        v = 1; p = m_prio[i]; id = 24'(16 + i);
      end
    if (!(v && p < m_cppr)) id = 0;
    return {m_cppr, id};
  endfunction

  function automatic logic m_deliv();
    logic [7:0] p;
    return m_best(p)[23:0] != 0;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [3:0] be, input logic [7:0] a,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_be = be; bus_addr = a; bus_wdata = wd;
    #1 rd = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic wr(input logic [3:0] be, input logic [7:0] a, input logic [31:0] wd);
    logic [31:0] d;
    access(1, be, a, wd, d);
    if (a == 8'h00 && be[3]) m_cppr = wd[31:24];
    if (a == 8'h0C && be[0]) m_mfrr = wd[7:0];
    for (int i = 0; i < N; i++) if (a == 8'(16 + 4*i) && be[0]) m_prio[i] = wd[7:0];
  endtask

  task automatic rd_ack(input string r, input logic poll);
    logic [31:0] d, e;
    logic [7:0] p;
    e = m_best(p);
    access(0, 0, poll ? 8'h04 : 8'h00, 0, d);
    chk(r, d, e);
    if (!poll && e[23:0] != 0) m_cppr = p;
  endtask

  task automatic rd_reg(input string r, input logic [7:0] a, input logic [7:0] e);
    logic [31:0] d;
    access(0, 0, a, 0, d);
    chk(r, d, {24'd0, e});
  endtask

  task automatic irq_chk(input string r);
    @(negedge clk); @(negedge clk);
    chk(r, {31'd0, irq_out}, {31'd0, m_deliv()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    m_cppr = 0; m_mfrr = 8'hff;
    for (int i = 0; i < N; i++) m_prio[i] = 8'hff;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq_out}, 0);
    rd_ack("R1 R9 poll reset", 1);
    rd_reg("R1 req", 8'h0C, 8'hff);
    for (int i = 0; i < N; i++) rd_reg("R1 prio", 8'(16 + 4*i), 8'hff);

    // R7 readback
    wr(4'b0001, 8'h10, 32'h0a); wr(4'b0001, 8'h14, 32'h05);
    rd_reg("R7 prio0", 8'h10, 8'h0a); rd_reg("R7 prio1", 8'h14, 8'h05);
    wr(4'b0010, 8'h10, 32'h3300); rd_reg("R7 lane ignored", 8'h10, 8'h0a);
    wr(4'b0001, 8'h10, 32'hff); wr(4'b0001, 8'h14, 32'hff);

    // R5 strict compare, R6 IPI, R2 ids
    src_lines[0] = 1;
    wr(4'b0001, 8'h10, 32'h06);
    wr(4'b0001, 8'h0C, 32'h04);
    irq_chk("R4 blocked at 0");
    wr(4'b1000, 8'h00, 32'h06_ffffff);
    irq_chk("R5 IPI under 6");
    rd_ack("R2 R3 ack IPI", 0);
    chk("R3 cppr after ack", {24'd0, m_cppr}, 32'h04);
    rd_ack("R3 nothing while in service", 0);
    wr(4'b0001, 8'h0C, 32'hff);
    wr(4'b1111, 8'h00, 32'h06_000002);
    irq_chk("R5 line at 6 held off");
    rd_ack("R5 ack none", 0);
    wr(4'b1000, 8'h00, 32'h07_000000);
    irq_chk("R5 line at 6 under 7");
    rd_ack("R2 ack line 16", 0);
    wr(4'b1111, 8'h00, 32'h07_000010);
    irq_chk("R10 level re-present");
    rd_ack("R10 re-ack", 0);
    src_lines[0] = 0;
    wr(4'b1111, 8'h00, 32'hff_000010);
    irq_chk("R10 line dropped");

    // R8 ties
    wr(4'b0001, 8'h14, 32'h03); wr(4'b0001, 8'h18, 32'h03);
    src_lines = 4'b0110;
    wr(4'b0001, 8'h0C, 32'h03);
    rd_ack("R8 IPI wins tie", 1);
    wr(4'b0001, 8'h0C, 32'hff);
    rd_ack("R8 lower index wins", 1);
    wr(4'b0001, 8'h18, 32'h02);
    rd_ack("R8 lower prio wins", 1);
    rd_ack("R9 poll stable", 1);
    src_lines = 0;
    wr(4'b1000, 8'h00, 32'h0);

    // random
    for (int k = 0; k < 600; k++) begin
      int op = $urandom_range(0, 6);
      logic [7:0] v = ($urandom_range(0, 5) == 0) ? 8'hff : 8'($urandom_range(0, 12));
      case (op)
        0: wr(4'b1000, 8'h00, {v, 24'($urandom)});
        1: wr(4'b0001, 8'h0C, {24'd0, v});
        2: wr(4'b0001, 8'(16 + 4*$urandom_range(0, N-1)), {24'd0, v});
        3: begin @(negedge clk); src_lines = 4'($urandom); end
        4: rd_ack("R2 R3 random ack", 0);
        5: rd_ack("R9 random poll", 1);
        default: rd_reg("R6 R7 random read", 8'h0C, m_mfrr);
      endcase
      irq_chk("R11 random irq");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule